// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Port Model

This block is a synthesizable device-side model of a 16-bit asynchronous static-RAM port. It is meant to sit on a chip's external memory bus as a target that a memory controller can be checked against. The controller drives active-low chip select, write strobe, output enable and one enable per byte lane, plus an address and write data. The model decodes these pins into its access modes: deselected, output off, read of one lane or both lanes, and write of one lane or both lanes. It stores the written bytes in a word array whose depth is a parameter.

The pins have no timing relationship to the model's clock. Every input passes through a reset-initialised synchroniser chain of `SYNC_STAGES` flops, and all decoding works on the synchronised copy. The data bus is delivered at pad level: `dq_i` is the incoming bus, `dq_o` is the outgoing bus, and `dq_oe_o` holds one drive enable per lane. A lane whose enable is low is high-impedance at the pad, and its `dq_o` byte is held at zero.

A write-protect input models the supply-low condition. While it is high, no write reaches the array. The model takes a full 20-bit address but decodes only the low log2(`DEPTH`) bits, so the array stays small.

Top module: `sram_lane_port`

## Requirements
- R1: While the synchronised chip select is high (deselected), both bits of `dq_oe_o` are 0 and `dq_o` is zero, whatever the other pins are.
- R2: With chip select low and the write strobe high, both lanes are off if output enable is high or if both byte enables are high.
- R3: A read needs chip select low, write strobe high and output enable low. Lane k drives `dq_oe_o[k]`=1 only when `be_n_i[k]` is low. Lane 0 is `dq[7:0]` and lane 1 is `dq[15:8]`. A driven lane carries the stored byte at the addressed word.
- R4: While chip select and the write strobe are both low, neither lane drives. Output enable has no effect, including when it falls together with or after the write strobe.
- R5: A lane's byte is stored at the first sampled cycle at which its write overlap ends. The overlap is chip select low, write strobe low and that lane's enable low, and it ends when any one of the three goes high. The address and data stored are the last ones sampled while the overlap was active.
- R6: A write changes only the lanes whose byte enable was low. The other byte of the word keeps its old value.
- R7: While `wr_inhibit_i` is high, nothing is stored. This also holds for an overlap that was already running when the inhibit rose.
- R8: A pin change shows at the outputs after exactly `SYNC_STAGES`+1 rising clock edges. That is 3 edges by default.
- R9: Only address bits [log2(DEPTH)-1:0] select the word. Addresses that differ only above those bits reach the same word.
- R10: Reset clears the array to zero and turns both lanes off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 20 | Word address pins |
| ce_n_i | input | 1 | Chip select, active low |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| be_n_i | input | 2 | Byte enables, active low; bit 0 lower lane, bit 1 upper lane |
| wr_inhibit_i | input | 1 | Supply-low write protect, active high |
| dq_i | input | 16 | Data bus as seen at the pads |
| dq_o | output | 16 | Read data driven towards the pads |
| dq_oe_o | output | 2 | Per-lane pad drive enable |

## Verification
The bench runs full-word, lower-only and upper-only writes to the same word, and reads back after each one. This separates correct lane masking from writes that spill into the neighbouring byte. Reads are repeated with output enable high, with both byte enables high, and with chip select high. A write held with output enable low shows that the strobe, not output enable, decides whether the bus is driven. Other patterns cover an address that moves during an overlap, an inhibit that rises in the middle of an overlap, and an address above the array depth; these expose wrong address capture, a leaky protect and wrong address decoding. A cycle-accurate reference model is compared against every clock, so a shift of one cycle in latency also shows up.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;
  localparam int LANES     = 2;
  localparam int LANE_W    = 8;
  localparam int WORD_W    = LANES * LANE_W;
  localparam int ADDR_PINS = 20;

  // synchronised control pins, all active low except the inhibit
  typedef struct packed {
    logic             ce_n;
    logic             we_n;
    logic             oe_n;
    logic             inh;
    logic [LANES-1:0] be_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                inh: 1'b1, be_n: {LANES{1'b1}}};
endpackage

// File: rtl/sram_pin_sync.sv
module sram_pin_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_port_pkg::*;
(
  input  ctl_t             ctl,
  output logic [LANES-1:0] rd_lane,
  output logic [LANES-1:0] wr_lane
);
  logic sel, wr_mode, rd_mode;

  assign sel     = ~ctl.ce_n;
  assign wr_mode = sel & ~ctl.we_n;
  assign rd_mode = sel & ctl.we_n & ~ctl.oe_n;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign rd_lane[k] = rd_mode & ~ctl.be_n[k];
    assign wr_lane[k] = wr_mode & ~ctl.be_n[k] & ~ctl.inh;
  end
endmodule

// File: rtl/sram_write_engine.sv
module sram_write_engine
  import sram_port_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  wr_lane,
  input  logic              inh,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] data,
  output logic [LANES-1:0]  commit,
  output logic [IDX_W-1:0]  c_idx,
  output logic [WORD_W-1:0] c_data
);
  logic [LANES-1:0]  pend;
  logic [IDX_W-1:0]  pidx;
  logic [WORD_W-1:0] pdata;

  // a lane commits when its overlap ends, unless protection is active
  assign commit = pend & ~wr_lane & {LANES{~inh}};
  assign c_idx  = pidx;
  assign c_data = pdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      pidx  <= '0;
      pdata <= '0;
    end else begin
      pend <= wr_lane;
      if (|wr_lane) pidx <= idx;
      for (int k = 0; k < LANES; k++)
        if (wr_lane[k]) pdata[k*LANE_W +: LANE_W] <= data[k*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/sram_word_array.sv
module sram_word_array
  import sram_port_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  we_lane,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [WORD_W-1:0] w_data,
  input  logic [IDX_W-1:0]  r_idx,
  output logic [WORD_W-1:0] r_data
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int k = 0; k < LANES; k++)
        if (we_lane[k]) mem[w_idx][k*LANE_W +: LANE_W] <= w_data[k*LANE_W +: LANE_W];
    end
  end

  assign r_data = mem[r_idx];
endmodule

// File: rtl/sram_lane_port.sv
module sram_lane_port
  import sram_port_pkg::*;
#(
  parameter int DEPTH       = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_PINS-1:0] addr_i,
  input  logic                 ce_n_i,
  input  logic                 we_n_i,
  input  logic                 oe_n_i,
  input  logic [LANES-1:0]     be_n_i,
  input  logic                 wr_inhibit_i,
  input  logic [WORD_W-1:0]    dq_i,
  output logic [WORD_W-1:0]    dq_o,
  output logic [LANES-1:0]     dq_oe_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CTL_W = $bits(ctl_t);

  ctl_t              ctl_raw, ctl_s;
  logic [IDX_W-1:0]  idx_s, c_idx;
  logic [WORD_W-1:0] data_s, rd_word, c_data;
  logic [LANES-1:0]  rd_lane, wr_lane, commit_lane;
  logic              addr_hi_unused;

  assign addr_hi_unused = ^addr_i[ADDR_PINS-1:IDX_W];
  assign ctl_raw = '{ce_n: ce_n_i, we_n: we_n_i, oe_n: oe_n_i,
                     inh: wr_inhibit_i, be_n: be_n_i};

  sram_pin_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST(CTL_IDLE)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s));
  sram_pin_sync #(.W(IDX_W), .STAGES(SYNC_STAGES), .RST('0)) u_sync_addr (
    .clk(clk), .rst_n(rst_n), .d(addr_i[IDX_W-1:0]), .q(idx_s));
  sram_pin_sync #(.W(WORD_W), .STAGES(SYNC_STAGES), .RST('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d(dq_i), .q(data_s));

  sram_mode_decode u_decode (.ctl(ctl_s), .rd_lane(rd_lane), .wr_lane(wr_lane));

  sram_write_engine #(.IDX_W(IDX_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_lane(wr_lane), .inh(ctl_s.inh),
    .idx(idx_s), .data(data_s), .commit(commit_lane), .c_idx(c_idx), .c_data(c_data));

  sram_word_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we_lane(commit_lane), .w_idx(c_idx), .w_data(c_data),
    .r_idx(idx_s), .r_data(rd_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe_o <= '0;
      dq_o    <= '0;
    end else begin
      dq_oe_o <= rd_lane;
      for (int k = 0; k < LANES; k++)
        dq_o[k*LANE_W +: LANE_W] <= rd_lane[k] ? rd_word[k*LANE_W +: LANE_W] : '0;
    end
  end
endmodule

// File: rtl/sram_lane_port_chk.sv
module sram_lane_port_chk
  import sram_port_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input ctl_t             ctl_s,
  input logic [LANES-1:0] commit_lane,
  input logic [LANES-1:0] dq_oe_o
);
  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_s.ce_n |=> dq_oe_o == '0);

  a_r2_output_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_s.ce_n && ctl_s.we_n && (ctl_s.oe_n || (&ctl_s.be_n))) |=> dq_oe_o == '0);

  a_r3_lane_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_s.ce_n && ctl_s.we_n && !ctl_s.oe_n) |=> dq_oe_o == ~$past(ctl_s.be_n));

  a_r4_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_s.ce_n && !ctl_s.we_n) |=> dq_oe_o == '0);

  a_r5_commit_after_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (|commit_lane) |-> $past(!ctl_s.ce_n && !ctl_s.we_n));

  a_r7_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_s.inh |-> commit_lane == '0);
endmodule

bind sram_lane_port sram_lane_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_s(ctl_s), .commit_lane(commit_lane), .dq_oe_o(dq_oe_o));

// File: tb/sram_lane_port_bench.sv
module sram_lane_port_bench;
  localparam int DEPTH = 1024;
  localparam int S     = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        ce_n, we_n, oe_n, inh;
  logic [1:0]  be_n;
  logic [19:0] addr;
  logic [15:0] din;
  logic [15:0] dq_o;
  logic [1:0]  dq_oe_o;

  sram_lane_port #(.DEPTH(DEPTH), .SYNC_STAGES(S)) u_sram_lane_port (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .ce_n_i(ce_n), .we_n_i(we_n),
    .oe_n_i(oe_n), .be_n_i(be_n), .wr_inhibit_i(inh), .dq_i(din),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o));

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  logic [41:0] hist[$];
  logic [15:0] mm [DEPTH];
  bit   [1:0]  pend;
  logic [15:0] pdata;
  int          paddr;
  logic [1:0]  exp_oe;
  logic [15:0] exp_dq;
  string       exp_tag;
  bit          live = 0;

  always @(posedge clk) begin
    logic [41:0] s;
    bit ce, we, oe, ih;
    bit [1:0] be, act;
    int idx;
    if (!rst_n) begin
      hist.delete();
      foreach (mm[i]) mm[i] = '0;
      pend = '0; pdata = '0; paddr = 0;
      exp_oe = '0; exp_dq = '0; exp_tag = "R10"; live = 1;
    end else begin
      hist.push_back({ce_n, we_n, oe_n, inh, be_n, addr, din});
      if (hist.size() > S) s = hist.pop_front();
      else s = {4'b1111, 2'b11, 20'h0, 16'h0};
      {ce, we, oe, ih, be} = s[41:36];
      idx = int'(s[35:16]) % DEPTH;
      exp_oe = '0; exp_dq = '0;
      if (ce) exp_tag = "R1";
      else if (!we) exp_tag = "R4";
      else if (oe || be == 2'b11) exp_tag = "R2";
      else begin
        exp_tag = "R3";
        for (int k = 0; k < 2; k++)
          if (!be[k]) begin
            exp_oe[k] = 1'b1;
            exp_dq[k*8 +: 8] = mm[idx][k*8 +: 8];
          end
      end
      for (int k = 0; k < 2; k++) act[k] = !ce && !we && !be[k] && !ih;
      for (int k = 0; k < 2; k++)
        if (pend[k] && !act[k] && !ih) mm[paddr][k*8 +: 8] = pdata[k*8 +: 8];
      for (int k = 0; k < 2; k++)
        if (act[k]) pdata[k*8 +: 8] = s[k*8 +: 8];
      if (|act) paddr = idx;
      pend = act;
    end
  end

  always @(negedge clk) begin
    if (rst_n && live && !done)
      chk({dq_oe_o, dq_o} === {exp_oe, exp_dq}, exp_tag, {dq_oe_o, dq_o}, {exp_oe, exp_dq});
  end

  task automatic drive(bit c, bit w, bit o, bit ih, bit [1:0] b, logic [19:0] a, logic [15:0] d);
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o; inh = ih; be_n = b; addr = a; din = d;
  endtask

  task automatic idle(int n);
    drive(1, 1, 1, 0, 2'b11, 20'h0, 16'h0);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_word(logic [19:0] a, logic [15:0] d, bit [1:0] b, bit o);
    drive(0, 0, o, 0, b, a, d);
    @(negedge clk);
    idle(S + 2);
  endtask

  task automatic read_check(logic [19:0] a, bit [1:0] b, logic [1:0] eo, logic [15:0] ed, string tag);
    drive(0, 1, 0, 0, b, a, 16'h0);
    repeat (S + 1) @(negedge clk);
    chk({dq_oe_o, dq_o} === {eo, ed}, tag, {dq_oe_o, dq_o}, {eo, ed});
    idle(1);
  endtask

  initial begin
    rst_n = 0;
    ce_n = 1; we_n = 1; oe_n = 1; inh = 0; be_n = 2'b11; addr = '0; din = '0;
    repeat (4) @(negedge clk);
    chk(dq_oe_o == 2'b00, "R10 reset lanes off", {dq_oe_o, dq_o}, 18'h0);
    rst_n = 1;
    idle(S + 2);
    read_check(20'd5, 2'b00, 2'b11, 16'h0000, "R10 cleared word");

    write_word(20'd3, 16'h1234, 2'b00, 1);
    read_check(20'd3, 2'b00, 2'b11, 16'h1234, "R5 word write");
    write_word(20'd3, 16'h99AB, 2'b10, 1);
    read_check(20'd3, 2'b00, 2'b11, 16'h12AB, "R6 lower write keeps upper");
    write_word(20'd3, 16'hCD77, 2'b01, 1);
    read_check(20'd3, 2'b00, 2'b11, 16'hCDAB, "R6 upper write keeps lower");
    read_check(20'd3, 2'b10, 2'b01, 16'h00AB, "R3 lower lane read");
    read_check(20'd3, 2'b01, 2'b10, 16'hCD00, "R3 upper lane read");

    drive(0, 1, 1, 0, 2'b00, 20'd3, 16'h0);
    repeat (S + 1) @(negedge clk);
    chk(dq_oe_o == 2'b00, "R2 oe high", {dq_oe_o, dq_o}, 18'h0);
    drive(0, 1, 0, 0, 2'b11, 20'd3, 16'h0);
    repeat (S + 1) @(negedge clk);
    chk(dq_oe_o == 2'b00, "R2 both bytes off", {dq_oe_o, dq_o}, 18'h0);
    drive(1, 1, 0, 0, 2'b00, 20'd3, 16'h0);
    repeat (S + 1) @(negedge clk);
    chk(dq_oe_o == 2'b00, "R1 deselected", {dq_oe_o, dq_o}, 18'h0);

    // write held with output enable low must never drive
    drive(0, 0, 0, 0, 2'b00, 20'd8, 16'hBEEF);
    repeat (S + 1) @(negedge clk);
    chk(dq_oe_o == 2'b00, "R4 write with oe low", {dq_oe_o, dq_o}, 18'h0);
    idle(S + 2);
    read_check(20'd8, 2'b00, 2'b11, 16'hBEEF, "R4 write still stored");

    // inhibited write and inhibit rising mid-overlap
    drive(0, 0, 1, 1, 2'b00, 20'd7, 16'hFFFF);
    @(negedge clk);
    idle(S + 2);
    read_check(20'd7, 2'b00, 2'b11, 16'h0000, "R7 inhibited write");
    drive(0, 0, 1, 0, 2'b00, 20'd9, 16'hA5A5);
    drive(0, 0, 1, 1, 2'b00, 20'd9, 16'hA5A5);
    drive(1, 1, 1, 1, 2'b11, 20'd0, 16'h0);
    repeat (S + 2) @(negedge clk);
    idle(1);
    read_check(20'd9, 2'b00, 2'b11, 16'h0000, "R7 inhibit mid overlap");

    // address moves during an overlap: last sampled values win
    drive(0, 0, 1, 0, 2'b00, 20'd10, 16'h1111);
    @(negedge clk);
    drive(0, 0, 1, 0, 2'b00, 20'd11, 16'h2222);
    @(negedge clk);
    idle(S + 2);
    read_check(20'd11, 2'b00, 2'b11, 16'h2222, "R5 last address used");
    read_check(20'd10, 2'b00, 2'b11, 16'h0000, "R5 earlier address untouched");

    // upper address bits ignored
    write_word(20'h00403, 16'h5555, 2'b00, 1);
    read_check(20'd3, 2'b00, 2'b11, 16'h5555, "R9 alias low index");
    read_check(20'hFFC03, 2'b00, 2'b11, 16'h5555, "R9 alias high bits");

    // latency: S+1 edges from pin change to output
    idle(S + 2);
    drive(0, 1, 0, 0, 2'b00, 20'd3, 16'h0);
    repeat (S) @(negedge clk);
    chk(dq_oe_o == 2'b00, "R8 not yet driven", {dq_oe_o, dq_o}, 18'h0);
    @(negedge clk);
    chk(dq_oe_o == 2'b11 && dq_o == 16'h5555, "R8 driven on time", {dq_oe_o, dq_o}, {2'b11, 16'h5555});
    idle(S + 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule